// File: doc/BRIEF.md
# Sliding-Window Local Peak Detector

This block watches a stream of signed samples, qualified by a valid strobe, and decides for every accepted sample whether the centre of the most recent window of samples is a local maximum. The window is held in a shift register. Its length is fixed at elaboration and is 11 by default. The centre sample counts as a peak under two conditions. First, no other sample in the window is larger than it, so neighbours of equal value still allow a peak. Second, it is strictly above a threshold given on an input port.

Each accepted sample produces one registered result one cycle later. The result carries three things: the centre sample, a detected flag, and a running sample index. The index starts at 1 for the first accepted sample after reset and wraps modulo 2^32. Each detection is also written into a short history chain. The chain holds the index and the centre value of the most recent peaks, so downstream logic can read several peaks and not only the last one.

Top module: `win_peak_detect`

## Requirements
- R1: The centre of the window is the 6th of the 11 most recent valid samples. Its value is driven on `midSample` and equals the sample accepted five valid samples before the newest one, or 0 while fewer than six samples have arrived since reset.
- R2: A peak needs every sample in the window to be less than or equal to the centre. Neighbours equal to the centre still allow detection, and any neighbour larger than the centre blocks it.
- R3: A peak also needs the centre to be strictly greater than the signed `threshold` input. A centre equal to the threshold is not a peak.
- R4: `detected` stays low until 11 valid samples have been accepted since reset. The evaluation of the 11th sample is the first that can detect.
- R5: `sampleIdx` is 1 for the first valid sample after reset and increases by exactly one for each later valid sample.
- R6: A cycle with `inValid` low is ignored. It does not shift the window and does not advance the index. In the next cycle `outValid` and `detected` are low and the history is unchanged.
- R7: For a valid input at clock edge N, `outValid`, `midSample`, `detected` and `sampleIdx` show that evaluation in the cycle after edge N. `detected` is never high while `outValid` is low.
- R8: On a detection, history entry 0 (bits [31:0] of `histIdx`, bits [15:0] of `histVal`, bit 0 of `histValid`) takes the index and centre value of that peak in the same cycle as `detected`. Entry k takes the old contents of entry k-1.
- R9: The history holds 4 entries, with entry 0 the newest. When a fifth peak arrives, the oldest entry is dropped. The valid bits fill from entry 0 upward.
- R10: Without a detection, all history entries and valid bits keep their values.
- R11: A synchronous active-high `rst` clears the window, the index, the outputs and the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `inSample` |
| inSample | input | 16 | Signed input sample |
| threshold | input | 16 | Signed level the centre must exceed |
| outValid | output | 1 | One evaluation is presented this cycle |
| midSample | output | 16 | Signed centre sample of the evaluated window |
| detected | output | 1 | Centre is a peak above threshold |
| sampleIdx | output | 32 | Running index of the evaluated sample |
| histIdx | output | 128 | Four 32-bit peak indices, entry 0 in the low bits |
| histVal | output | 64 | Four 16-bit signed peak values, entry 0 in the low bits |
| histValid | output | 4 | Per-entry valid bits |

## Verification
Two functions can fall in the same cycle. The first is the fill gate lifting, on the evaluation of the 11th sample. The second is a detection that pushes the history. The bench provokes this with a centre peak placed so that the very first full window qualifies. It then checks that the flag, index 11 and the new entry 0 all appear together. Earlier would-be peaks, seen against the zeros left by reset, must stay suppressed. A second collision is tested as well: a fifth push that has to drop the oldest entry while it shifts the others. This is judged on every entry's index, value and valid bit.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
  typedef struct packed {
    logic shiftEn;
    logic evalArm;
  } ctrl_strobe_t;
endpackage

// File: rtl/pkd_ctrl.sv
module pkd_ctrl
  import pkd_pkg::*;
#(
  parameter int WIN_LEN = 11,
  parameter int IDX_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output ctrl_strobe_t     strobe,
  output logic [IDX_W-1:0] idxNext
);
  localparam int FILL_W = $clog2(WIN_LEN + 1);
  localparam logic [FILL_W-1:0] ARM_AT  = FILL_W'(WIN_LEN - 1);
  localparam logic [FILL_W-1:0] FULL_AT = FILL_W'(WIN_LEN);

  logic [FILL_W-1:0] fillCnt;
  logic [IDX_W-1:0]  idxCnt;

  assign idxNext = idxCnt + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
      idxCnt  <= '0;
    end else if (inValid) begin
      idxCnt <= idxNext;
      if (fillCnt != FULL_AT) fillCnt <= fillCnt + FILL_W'(1);
    end
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.evalArm = inValid && (fillCnt >= ARM_AT);
  end

  // R6: idle cycles leave the index alone
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(idxCnt));
  // R4: the fill counter saturates at the window length
  p_fill_sat_r4: assert property (@(posedge clk) disable iff (rst)
    fillCnt <= FULL_AT);
endmodule

// File: rtl/pkd_datapath.sv
module pkd_datapath
  import pkd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int WIN_LEN    = 11,
  parameter int IDX_W      = 32,
  parameter int HIST_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrl_strobe_t                 strobe,
  input  logic signed [DATA_W-1:0]     inSample,
  input  logic signed [DATA_W-1:0]     threshold,
  input  logic [IDX_W-1:0]             idxNext,
  output logic                         outValid,
  output logic signed [DATA_W-1:0]     midSample,
  output logic                         detected,
  output logic [IDX_W-1:0]             sampleIdx,
  output logic [HIST_DEPTH*IDX_W-1:0]  histIdx,
  output logic [HIST_DEPTH*DATA_W-1:0] histVal,
  output logic [HIST_DEPTH-1:0]        histValid
);
  localparam int MID  = (WIN_LEN + 1) / 2 - 1;
  localparam int LAST = WIN_LEN - 1;

  logic signed [DATA_W-1:0] win    [WIN_LEN];
  logic signed [DATA_W-1:0] nxtWin [WIN_LEN];
  logic [WIN_LEN-1:0]       leOk;
  logic signed [DATA_W-1:0] midNow;
  logic                     aboveThr;
  logic                     hit;
  logic                     push;

  always_comb begin
    nxtWin[0] = inSample;
    for (int i = 1; i <= LAST; i++) nxtWin[i] = win[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_LEN; i++) win[i] <= '0;
    end else if (strobe.shiftEn) begin
      for (int i = 0; i < WIN_LEN; i++) win[i] <= nxtWin[i];
    end
  end

  assign midNow = nxtWin[MID];

  for (genvar g = 0; g < WIN_LEN; g++) begin : g_cmp
    assign leOk[g] = (nxtWin[g] <= midNow);
  end

  assign aboveThr = (midNow > threshold);
  assign hit      = (&leOk) && aboveThr;
  assign push     = strobe.shiftEn && strobe.evalArm && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      detected  <= 1'b0;
      midSample <= '0;
      sampleIdx <= '0;
    end else begin
      outValid <= strobe.shiftEn;
      detected <= push;
      if (strobe.shiftEn) begin
        midSample <= midNow;
        sampleIdx <= idxNext;
      end
    end
  end

  logic [IDX_W-1:0]         hIdx [HIST_DEPTH];
  logic signed [DATA_W-1:0] hVal [HIST_DEPTH];
  logic [HIST_DEPTH-1:0]    hVld;

  for (genvar h = 0; h < HIST_DEPTH; h++) begin : g_hist
    if (h == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          hIdx[h] <= '0;
          hVal[h] <= '0;
          hVld[h] <= 1'b0;
        end else if (push) begin
          hIdx[h] <= idxNext;
          hVal[h] <= midNow;
          hVld[h] <= 1'b1;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          hIdx[h] <= '0;
          hVal[h] <= '0;
          hVld[h] <= 1'b0;
        end else if (push) begin
          hIdx[h] <= hIdx[h-1];
          hVal[h] <= hVal[h-1];
          hVld[h] <= hVld[h-1];
        end
      end
      // R9: valid bits fill from the head downward
      p_hist_fill_r9: assert property (@(posedge clk) disable iff (rst)
        hVld[h] |-> hVld[h-1]);
    end
    assign histIdx[h*IDX_W +: IDX_W]   = hIdx[h];
    assign histVal[h*DATA_W +: DATA_W] = hVal[h];
  end
  assign histValid = hVld;

  // R7: a detection is always part of a presented result
  p_det_valid_r7: assert property (@(posedge clk) disable iff (rst)
    detected |-> outValid);
  // R3: a reported peak lies strictly above the threshold seen at its edge
  p_det_thr_r3: assert property (@(posedge clk) disable iff (rst)
    detected |-> (midSample > $past(threshold)));
  // R8: the history head matches the peak reported in the same cycle
  p_hist_head_r8: assert property (@(posedge clk) disable iff (rst)
    detected |-> (hVld[0] && hIdx[0] == sampleIdx && hVal[0] == midSample));
  // R10: no detection, no history movement
  p_hist_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !detected |-> ($stable(histIdx) && $stable(histVal) && $stable(hVld)));
  // R6: an idle input yields no result next cycle
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> !outValid);
endmodule

// File: rtl/win_peak_detect.sv
module win_peak_detect
  import pkd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int WIN_LEN    = 11,
  parameter int IDX_W      = 32,
  parameter int HIST_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic signed [DATA_W-1:0]     inSample,
  input  logic signed [DATA_W-1:0]     threshold,
  output logic                         outValid,
  output logic signed [DATA_W-1:0]     midSample,
  output logic                         detected,
  output logic [IDX_W-1:0]             sampleIdx,
  output logic [HIST_DEPTH*IDX_W-1:0]  histIdx,
  output logic [HIST_DEPTH*DATA_W-1:0] histVal,
  output logic [HIST_DEPTH-1:0]        histValid
);
  ctrl_strobe_t     strobe;
  logic [IDX_W-1:0] idxNext;

  pkd_ctrl #(.WIN_LEN(WIN_LEN), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .idxNext(idxNext)
  );

  pkd_datapath #(.DATA_W(DATA_W), .WIN_LEN(WIN_LEN), .IDX_W(IDX_W),
                 .HIST_DEPTH(HIST_DEPTH)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inSample(inSample), .threshold(threshold), .idxNext(idxNext),
    .outValid(outValid), .midSample(midSample), .detected(detected),
    .sampleIdx(sampleIdx), .histIdx(histIdx), .histVal(histVal),
    .histValid(histValid)
  );
endmodule

// File: tb/win_peak_detect_tb_top.sv
module win_peak_detect_tb_top;
  localparam int HD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] inSample = '0;
  logic signed [15:0] threshold = 16'sd10;
  logic outValid, detected;
  logic signed [15:0] midSample;
  logic [31:0] sampleIdx;
  logic [HD*32-1:0] histIdx;
  logic [HD*16-1:0] histVal;
  logic [HD-1:0] histValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int sent [0:1023];
  int nSent = 0;
  longint eIdx [HD];
  longint eVal [HD];
  bit eVld [HD];

  always #5 clk = ~clk;

  win_peak_detect dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .threshold(threshold), .outValid(outValid), .midSample(midSample),
    .detected(detected), .sampleIdx(sampleIdx), .histIdx(histIdx),
    .histVal(histVal), .histValid(histValid)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkHist(string req);
    for (int i = 0; i < HD; i++) begin
      check({req, " hist valid"}, longint'(histValid[i]), longint'(eVld[i]));
      check({req, " hist idx"}, longint'(histIdx[i*32 +: 32]), eIdx[i]);
      check({req, " hist val"}, longint'($signed(histVal[i*16 +: 16])), eVal[i]);
    end
  endtask

  function automatic bit expDet();
    int mid;
    if (nSent < 11) return 1'b0;
    mid = sent[nSent-6];
    for (int k = 0; k < 11; k++) if (sent[nSent-1-k] > mid) return 1'b0;
    return mid > int'(threshold);
  endfunction

  task automatic doReset();
    inValid = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    nSent = 0;
    for (int i = 0; i < HD; i++) begin eIdx[i] = 0; eVal[i] = 0; eVld[i] = 0; end
  endtask

  task automatic sendSample(int v);
    bit d;
    inValid = 1'b1;
    inSample = 16'(v);
    @(posedge clk);
    #1;
    sent[nSent] = v;
    nSent++;
    d = expDet();
    if (d) begin
      for (int i = HD-1; i > 0; i--) begin
        eIdx[i] = eIdx[i-1]; eVal[i] = eVal[i-1]; eVld[i] = eVld[i-1];
      end
      eIdx[0] = nSent; eVal[0] = sent[nSent-6]; eVld[0] = 1;
    end
    check("R7 outValid", longint'(outValid), 1);
    check("R5 index", longint'(sampleIdx), nSent);
    check("R1 centre", longint'(midSample), (nSent >= 6) ? sent[nSent-6] : 0);
    check((nSent < 11) ? "R4 detected" : "R2 R3 detected", longint'(detected), longint'(d));
    checkHist("R8 R9");
  endtask

  task automatic idle(int n, int junk);
    inValid = 1'b0;
    inSample = 16'(junk);
    repeat (n) begin
      @(posedge clk);
      #1;
      check("R6 outValid", longint'(outValid), 0);
      check("R6 detected", longint'(detected), 0);
      checkHist("R10");
    end
  endtask

  task automatic t_reset();
    doReset();
    check("R11 outValid", longint'(outValid), 0);
    check("R11 detected", longint'(detected), 0);
    check("R11 index", longint'(sampleIdx), 0);
    check("R11 centre", longint'(midSample), 0);
    checkHist("R11");
  endtask

  task automatic t_first_fill();
    doReset();
    threshold = 16'sd10;
    sendSample(100);
    for (int i = 0; i < 4; i++) sendSample(0);
    sendSample(-3);
    for (int i = 0; i < 4; i++) sendSample(0);
    check("R4 no early peak", longint'(histValid[0]), 0);
    doReset();
    for (int i = 0; i < 5; i++) sendSample(1);
    sendSample(77);
    for (int i = 0; i < 4; i++) sendSample(2);
    sendSample(3);
    check("R4 first full detect", longint'(detected), 1);
    check("R4 first full index", longint'(sampleIdx), 11);
    check("R8 head idx", longint'(histIdx[31:0]), 11);
    check("R8 head val", longint'($signed(histVal[15:0])), 77);
    sendSample(0);
  endtask

  task automatic t_plateau();
    doReset();
    threshold = 16'sd10;
    for (int i = 0; i < 12; i++) sendSample(40);
    check("R2 equal neighbours", longint'(detected), 1);
    sendSample(41);
    check("R2 larger neighbour", longint'(detected), 0);
  endtask

  task automatic t_threshold();
    doReset();
    threshold = 16'sd10;
    for (int i = 0; i < 5; i++) sendSample(-20);
    sendSample(10);
    for (int i = 0; i < 5; i++) sendSample(-20);
    check("R3 equal to threshold", longint'(detected), 0);
    sendSample(11);
    for (int i = 0; i < 5; i++) sendSample(-20);
    check("R3 above threshold", longint'(detected), 1);
    threshold = -16'sd30;
    for (int i = 0; i < 12; i++) sendSample(-25);
  endtask

  task automatic t_gaps();
    doReset();
    threshold = 16'sd0;
    for (int i = 0; i < 8; i++) begin
      sendSample(i * 3);
      idle(2, 32767);
    end
    sendSample(50);
    idle(3, 32000);
    for (int i = 0; i < 5; i++) begin
      sendSample(5);
      idle(1, 30000);
    end
    check("R6 gaps ignored index", longint'(sampleIdx), 14);
  endtask

  task automatic t_history();
    doReset();
    threshold = 16'sd5;
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 5; i++) sendSample(0);
      sendSample(20 + p);
    end
    for (int i = 0; i < 5; i++) sendSample(0);
    idle(4, 999);
    check("R9 full", longint'(histValid), 15);
    check("R9 newest", longint'($signed(histVal[15:0])), 25);
    check("R9 oldest kept", longint'($signed(histVal[63:48])), 22);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_fill();
    t_plateau();
    t_threshold();
    t_gaps();
    t_history();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule